// File: doc/BRIEF.md
# Overlay Memory Access Decoder

This block sits between a processor core and its memories. For every access the core makes, it classifies the access as internal RAM, a control register or the external bus. The access names a space (program or data), a 14-bit word address and a direction. The upper half of program space and the lower half of data space can each be redirected to one of two 8K external pages. The page is chosen by a per-space overlay register. For an external access, the block forms the bus address from the page number, which goes on the top address bit, and the 13 low address bits.

The block holds its four control registers itself: the program overlay, the data overlay, the data wait-state count and the shared-select enable mask. They are reached as memory-mapped registers at the top 32 words of data space. The block inserts wait states on external data accesses. It drives the program, data and shared (composite) memory selects and raises an error pulse for illegal or reserved accesses. A mode input turns off program overlays and maps the low program half to the external bus. Each access uses a request/done handshake.

Top module: `ovl_mem_decoder`

## Requirements
- R1: With mode_b low, program addresses 0x0000–0x1FFF are always internal, and 0x2000–0x3FFF are internal while the program overlay is 0. An internal access shows int_hit together with done in its single access cycle.
- R2: With mode_b low and the program overlay at 1 or 2, program addresses 0x2000–0x3FFF go external. pm_sel is asserted and ext_addr = {overlay==2, addr[12:0]}. The access completes in one cycle.
- R3: For data addresses 0x0000–0x1FFF, a data overlay of 0 means internal. A data overlay of 1 or 2 means external, with dm_sel and ext_addr = {overlay==2, addr[12:0]}. ext_addr stays 0 whenever neither pm_sel nor dm_sel is high.
- R4: Data addresses 0x2000–0x3FDF are internal whatever the overlay, completing in one cycle.
- R5: Data addresses 0x3FE0–0x3FFF are control registers selected by addr[4:0], each access taking one cycle. Offset 0 is the program overlay in bits 3:0. Offset 1 is the data overlay in bits 3:0. Offset 2 is the wait count in bits 2:0. Offset 3 is the select enables in bits 3:0 (bit 0 program, 1 data, 2 boot, 3 I/O). A read returns the zero-extended value on rd_data in its access cycle. Other offsets read 0 and ignore writes. A write takes effect from the next access.
- R6: An external data access holds dm_sel for wait count + 1 cycles, with done in the last of them.
- R7: With mode_b high, program accesses use no overlay. Addresses 0x0000–0x1FFF are external with ext_addr = addr and pm_sel for one cycle. Addresses 0x2000–0x3FFF are reserved and give err. Any program access while the program overlay is nonzero gives err.
- R8: An access that consults an overlay register holding a value above 2 is not performed. err and done pulse for one cycle, with no select and ext_addr 0.
- R9: cm_sel is the OR of pm_sel, dm_sel, boot_sel_in and io_sel_in, each gated by its enable bit, in the same cycle.
- R10: After reset both overlays and the wait count are 0 and the enables are 4'b1011 (boot disabled). All select, done, error and data outputs are 0.
- R11: A request is accepted at a clock edge where req is high and no access is in progress. The access runs from the next cycle, and done pulses once in its last cycle. Requests during an access are ignored and leave ext_addr unchanged. A request held through done is accepted at the end of the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b | input | 1 | Overlay disable / low program half external |
| req | input | 1 | Access request |
| req_pm | input | 1 | 1 = program space, 0 = data space |
| req_we | input | 1 | 1 = write |
| req_addr | input | 14 | Word address |
| req_wdata | input | 16 | Write data (control registers) |
| boot_sel_in | input | 1 | Boot memory select from outside the block |
| io_sel_in | input | 1 | I/O select from outside the block |
| done | output | 1 | Last cycle of the access |
| int_hit | output | 1 | Access served by internal RAM |
| err | output | 1 | Illegal or reserved access |
| pm_sel | output | 1 | External program memory select |
| dm_sel | output | 1 | External data memory select |
| cm_sel | output | 1 | Composite memory select |
| ext_addr | output | 14 | External bus address |
| rd_data | output | 16 | Control register read data |

## Verification
Directed accesses sweep both spaces across every overlay value (0, 1, 2 and illegal ones) and across the half and register-window boundaries. This separates the internal, external, register and error paths and checks which bank bit ends up on ext_addr. Wait counts of 0, 3 and 7 show that the select length follows the register rather than a fixed value. A request held high through a long access shows that it is ignored while the access runs and accepted only after one idle cycle. Random accesses, with register writes mixed in and the boot and I/O selects toggling every cycle, check the composite select against every enable mask.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int MMR_CNT   = 32;
  localparam int MMR_IDX_W = $clog2(MMR_CNT);
  localparam int CSEN_W    = 4;

  typedef enum logic [2:0] {
    ACC_INT,
    ACC_MMR,
    ACC_EXT_PM,
    ACC_EXT_DM,
    ACC_ERR
  } acc_kind_e;

  localparam logic [MMR_IDX_W-1:0] MMR_POVL  = MMR_IDX_W'(0);
  localparam logic [MMR_IDX_W-1:0] MMR_DOVL  = MMR_IDX_W'(1);
  localparam logic [MMR_IDX_W-1:0] MMR_DWAIT = MMR_IDX_W'(2);
  localparam logic [MMR_IDX_W-1:0] MMR_CSEN  = MMR_IDX_W'(3);

  localparam int CS_PM   = 0;
  localparam int CS_DM   = 1;
  localparam int CS_BOOT = 2;
  localparam int CS_IO   = 3;

  localparam logic [CSEN_W-1:0] CSEN_RESET = 4'b1011;
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
  import ovl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OVL_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [MMR_IDX_W-1:0] idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [OVL_W-1:0]     povl,
  output logic [OVL_W-1:0]     dovl,
  output logic [WAIT_W-1:0]    dwait,
  output logic [CSEN_W-1:0]    csen,
  output logic [DATA_W-1:0]    rdata
);
  logic [OVL_W-1:0]  povl_q, povl_d;
  logic [OVL_W-1:0]  dovl_q, dovl_d;
  logic [WAIT_W-1:0] dwait_q, dwait_d;
  logic [CSEN_W-1:0] csen_q, csen_d;

  // write decode
  always_comb begin
    povl_d  = povl_q;
    dovl_d  = dovl_q;
    dwait_d = dwait_q;
    csen_d  = csen_q;
    if (wr_en) begin
      case (idx)
        MMR_POVL:  povl_d  = wdata[OVL_W-1:0];
        MMR_DOVL:  dovl_d  = wdata[OVL_W-1:0];
        MMR_DWAIT: dwait_d = wdata[WAIT_W-1:0];
        MMR_CSEN:  csen_d  = wdata[CSEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      povl_q  <= '0;
      dovl_q  <= '0;
      dwait_q <= '0;
      csen_q  <= CSEN_RESET;
    end else if (wr_en) begin
      povl_q  <= povl_d;
      dovl_q  <= dovl_d;
      dwait_q <= dwait_d;
      csen_q  <= csen_d;
    end
  end

  // read mux
  always_comb begin
    case (idx)
      MMR_POVL:  rdata = DATA_W'(povl_q);
      MMR_DOVL:  rdata = DATA_W'(dovl_q);
      MMR_DWAIT: rdata = DATA_W'(dwait_q);
      MMR_CSEN:  rdata = DATA_W'(csen_q);
      default:   rdata = '0;
    endcase
  end

  assign povl  = povl_q;
  assign dovl  = dovl_q;
  assign dwait = dwait_q;
  assign csen  = csen_q;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx > MMR_CSEN) |=> $stable({povl_q, dovl_q, dwait_q, csen_q})); // R5
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int OVL_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              is_pm,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_b,
  input  logic [OVL_W-1:0]  povl,
  input  logic [OVL_W-1:0]  dovl,
  input  logic [WAIT_W-1:0] dwait,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [WAIT_W-1:0] waits
);
  localparam int PAGE_W = ADDR_W - 1;

  logic              upper_half;
  logic              in_mmr;
  logic [PAGE_W-1:0] page_off;
  logic              povl_ok, povl_bank;
  logic              dovl_ok, dovl_bank;

  assign upper_half = addr[ADDR_W-1];
  assign in_mmr     = &addr[ADDR_W-1:MMR_IDX_W];
  assign page_off   = addr[PAGE_W-1:0];

  // overlay values 1 and 2 select page 0 and page 1
  assign povl_ok   = (povl == OVL_W'(1)) || (povl == OVL_W'(2));
  assign povl_bank = (povl == OVL_W'(2));
  assign dovl_ok   = (dovl == OVL_W'(1)) || (dovl == OVL_W'(2));
  assign dovl_bank = (dovl == OVL_W'(2));

  always_comb begin
    kind     = ACC_ERR;
    ext_addr = '0;
    waits    = '0;
    if (is_pm) begin
      if (mode_b) begin
        if (povl != '0 || upper_half) begin
          kind = ACC_ERR;
        end else begin
          kind     = ACC_EXT_PM;
          ext_addr = addr;
        end
      end else if (!upper_half || povl == '0) begin
        kind = ACC_INT;
      end else if (povl_ok) begin
        kind     = ACC_EXT_PM;
        ext_addr = {povl_bank, page_off};
      end else begin
        kind = ACC_ERR;
      end
    end else begin
      if (in_mmr) begin
        kind = ACC_MMR;
      end else if (upper_half || dovl == '0) begin
        kind = ACC_INT;
      end else if (dovl_ok) begin
        kind     = ACC_EXT_DM;
        ext_addr = {dovl_bank, page_off};
        waits    = dwait;
      end else begin
        kind = ACC_ERR;
      end
    end
  end
endmodule

// File: rtl/ovl_seq.sv
module ovl_seq
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  acc_kind_e            kind_in,
  input  logic [ADDR_W-1:0]    ext_in,
  input  logic [WAIT_W-1:0]    waits_in,
  input  logic                 we_in,
  input  logic [MMR_IDX_W-1:0] idx_in,
  input  logic [DATA_W-1:0]    wdata_in,
  output logic                 done,
  output logic                 int_hit,
  output logic                 err,
  output logic                 pm_sel,
  output logic                 dm_sel,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic                 mmr_rd,
  output logic                 mmr_wr,
  output logic [MMR_IDX_W-1:0] mmr_idx,
  output logic [DATA_W-1:0]    mmr_wdata
);
  logic                 busy_q, busy_d;
  acc_kind_e            kind_q;
  logic [ADDR_W-1:0]    ext_q;
  logic [WAIT_W-1:0]    cnt_q, cnt_d;
  logic                 we_q;
  logic [MMR_IDX_W-1:0] idx_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 load_en, cnt_en, last;

  // next state
  always_comb begin
    load_en = req && !busy_q;
    last    = busy_q && (cnt_q == '0);
    busy_d  = load_en || (busy_q && !last);
    cnt_en  = load_en || (busy_q && !last);
    cnt_d   = load_en ? waits_in : (cnt_q - WAIT_W'(1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= ACC_INT;
      ext_q   <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (load_en) begin
        kind_q  <= kind_in;
        ext_q   <= ext_in;
        we_q    <= we_in;
        idx_q   <= idx_in;
        wdata_q <= wdata_in;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // outputs
  always_comb begin
    done      = last;
    int_hit   = busy_q && (kind_q == ACC_INT);
    err       = busy_q && (kind_q == ACC_ERR);
    pm_sel    = busy_q && (kind_q == ACC_EXT_PM);
    dm_sel    = busy_q && (kind_q == ACC_EXT_DM);
    ext_addr  = (pm_sel || dm_sel) ? ext_q : '0;
    mmr_rd    = busy_q && (kind_q == ACC_MMR) && !we_q;
    mmr_wr    = last && (kind_q == ACC_MMR) && we_q;
    mmr_idx   = idx_q;
    mmr_wdata = wdata_q;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(pm_sel || dm_sel || int_hit || err)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(ext_addr)); // R11
  AST_DM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_sel && !done) |=> dm_sel); // R6
  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |-> done); // R1
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && ext_addr == '0)); // R8
endmodule

// File: rtl/ovl_mem_decoder.sv
module ovl_mem_decoder
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int OVL_W  = 4,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_b,
  input  logic              req,
  input  logic              req_pm,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              boot_sel_in,
  input  logic              io_sel_in,
  output logic              done,
  output logic              int_hit,
  output logic              err,
  output logic              pm_sel,
  output logic              dm_sel,
  output logic              cm_sel,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] rd_data
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign arst_n = rst_sync_q[1];

  logic [OVL_W-1:0]     povl, dovl;
  logic [WAIT_W-1:0]    dwait;
  logic [CSEN_W-1:0]    csen;
  logic [DATA_W-1:0]    reg_rdata;
  acc_kind_e            dec_kind;
  logic [ADDR_W-1:0]    dec_ext;
  logic [WAIT_W-1:0]    dec_waits;
  logic                 mmr_rd, mmr_wr;
  logic [MMR_IDX_W-1:0] mmr_idx;
  logic [DATA_W-1:0]    mmr_wdata;

  ovl_regs #(.DATA_W(DATA_W), .OVL_W(OVL_W), .WAIT_W(WAIT_W)) u_regs (
    .clk   (clk),
    .rst_n (arst_n),
    .wr_en (mmr_wr),
    .idx   (mmr_idx),
    .wdata (mmr_wdata),
    .povl  (povl),
    .dovl  (dovl),
    .dwait (dwait),
    .csen  (csen),
    .rdata (reg_rdata)
  );

  ovl_decode #(.ADDR_W(ADDR_W), .OVL_W(OVL_W), .WAIT_W(WAIT_W)) u_decode (
    .is_pm    (req_pm),
    .addr     (req_addr),
    .mode_b   (mode_b),
    .povl     (povl),
    .dovl     (dovl),
    .dwait    (dwait),
    .kind     (dec_kind),
    .ext_addr (dec_ext),
    .waits    (dec_waits)
  );

  ovl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (arst_n),
    .req       (req),
    .kind_in   (dec_kind),
    .ext_in    (dec_ext),
    .waits_in  (dec_waits),
    .we_in     (req_we),
    .idx_in    (req_addr[MMR_IDX_W-1:0]),
    .wdata_in  (req_wdata),
    .done      (done),
    .int_hit   (int_hit),
    .err       (err),
    .pm_sel    (pm_sel),
    .dm_sel    (dm_sel),
    .ext_addr  (ext_addr),
    .mmr_rd    (mmr_rd),
    .mmr_wr    (mmr_wr),
    .mmr_idx   (mmr_idx),
    .mmr_wdata (mmr_wdata)
  );

  // composite select: OR of the enabled individual selects
  logic [CSEN_W-1:0] sel_vec;
  always_comb begin
    sel_vec          = '0;
    sel_vec[CS_PM]   = pm_sel;
    sel_vec[CS_DM]   = dm_sel;
    sel_vec[CS_BOOT] = boot_sel_in;
    sel_vec[CS_IO]   = io_sel_in;
    cm_sel           = |(sel_vec & csen);
    rd_data          = mmr_rd ? reg_rdata : '0;
  end

  AST_CS_FOLLOWS_PM: assert property (@(posedge clk) disable iff (!arst_n)
    (pm_sel && csen[CS_PM]) |-> cm_sel); // R9
  AST_CS_MASKED: assert property (@(posedge clk) disable iff (!arst_n)
    (csen == '0) |-> !cm_sel); // R9
  AST_MODEB_NO_DM_ON_PM: assert property (@(posedge clk) disable iff (!arst_n)
    (pm_sel && ext_addr[ADDR_W-1]) |-> !dm_sel); // R2
endmodule

// File: tb/tb_ovl_mem_decoder.sv
module tb_ovl_mem_decoder;
  localparam int K_INT = 0, K_MMR = 1, K_PM = 2, K_DM = 3, K_ERR = 4;

  logic clk = 1'b0;
  logic rst_n, mode_b, req, req_pm, req_we, boot_sel_in, io_sel_in;
  logic [13:0] req_addr;
  logic [15:0] req_wdata;
  logic done, int_hit, err, pm_sel, dm_sel, cm_sel;
  logic [13:0] ext_addr;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [3:0] m_povl, m_dovl, m_csen;
  logic [2:0] m_dwait;

  always #2 clk = ~clk;

  ovl_mem_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .req(req), .req_pm(req_pm),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .boot_sel_in(boot_sel_in), .io_sel_in(io_sel_in), .done(done),
    .int_hit(int_hit), .err(err), .pm_sel(pm_sel), .dm_sel(dm_sel),
    .cm_sel(cm_sel), .ext_addr(ext_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL R11 watchdog expired actual=%0d expected<=100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mmr_val(input logic [4:0] idx);
    case (idx)
      5'd0: return {12'd0, m_povl};
      5'd1: return {12'd0, m_dovl};
      5'd2: return {13'd0, m_dwait};
      5'd3: return {12'd0, m_csen};
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit ovl_legal(input logic [3:0] v);
    return (v == 4'd1) || (v == 4'd2);
  endfunction

  task automatic model(input bit pm, input logic [13:0] a, output int k,
                       output logic [13:0] ea, output int cyc, output string tag);
    k = K_ERR; ea = 14'd0; cyc = 1;
    if (pm) begin
      if (mode_b) begin
        tag = "R7";
        if (m_povl == 0 && a < 14'h2000) begin k = K_PM; ea = a; end
      end else if (a < 14'h2000 || m_povl == 0) begin
        k = K_INT; tag = "R1";
      end else if (ovl_legal(m_povl)) begin
        k = K_PM; ea = {m_povl == 4'd2, a[12:0]}; tag = "R2";
      end else tag = "R8";
    end else begin
      if (a >= 14'h3FE0) begin k = K_MMR; tag = "R5"; end
      else if (a >= 14'h2000) begin k = K_INT; tag = "R4"; end
      else if (m_dovl == 0) begin k = K_INT; tag = "R3"; end
      else if (ovl_legal(m_dovl)) begin
        k = K_DM; ea = {m_dovl == 4'd2, a[12:0]}; cyc = m_dwait + 1; tag = "R6";
      end else tag = "R8";
    end
  endtask

  task automatic side();
    boot_sel_in = 1'($urandom % 2);
    io_sel_in   = 1'($urandom % 2);
  endtask

  function automatic logic exp_cm(input logic p, input logic d);
    return (p & m_csen[0]) | (d & m_csen[1]) | (boot_sel_in & m_csen[2]) |
           (io_sel_in & m_csen[3]);
  endfunction

  // one access; entered and left just after a falling edge while idle
  task automatic access(input bit pm, input logic [13:0] a, input bit we,
                        input logic [15:0] wd);
    int k, cyc, n;
    logic [13:0] ea;
    string tag;
    logic [4:0] exp_flags;
    logic [15:0] exp_rd;
    model(pm, a, k, ea, cyc, tag);
    exp_rd = (k == K_MMR && !we) ? mmr_val(a[4:0]) : 16'd0;
    req = 1'b1; req_pm = pm; req_addr = a; req_we = we; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    n = 0;
    forever begin
      side();
      #1;
      n++;
      exp_flags = {n == cyc, k == K_INT, k == K_PM, k == K_DM, k == K_ERR};
      check(tag, "done/int/pm/dm/err", 32'({done, int_hit, pm_sel, dm_sel, err}),
            32'(exp_flags));
      check(tag, "ext_addr", 32'(ext_addr), (k == K_PM || k == K_DM) ? 32'(ea) : 32'd0);
      check("R9", "cm_sel", 32'(cm_sel), 32'(exp_cm(k == K_PM, k == K_DM)));
      check(tag, "rd_data", 32'(rd_data), 32'(exp_rd));
      if (done || n >= cyc || n > 20) break;
      @(negedge clk);
    end
    if (k == K_MMR && we) begin
      case (a[4:0])
        5'd0: m_povl = wd[3:0];
        5'd1: m_dovl = wd[3:0];
        5'd2: m_dwait = wd[2:0];
        5'd3: m_csen = wd[3:0];
        default: ;
      endcase
    end
    @(negedge clk);
    side();
    #1;
    check("R11", "idle after done", 32'({done, int_hit, pm_sel, dm_sel, err}), 32'd0);
  endtask

  task automatic wr_reg(input logic [4:0] idx, input logic [15:0] v);
    access(1'b0, 14'h3FE0 + 14'(idx), 1'b1, v);
  endtask

  initial begin
    void'($urandom(32'h0BAD5EED));
    rst_n = 1'b0; mode_b = 1'b0; req = 1'b0; req_pm = 1'b0; req_we = 1'b0;
    req_addr = '0; req_wdata = '0; boot_sel_in = 1'b0; io_sel_in = 1'b0;
    m_povl = 0; m_dovl = 0; m_dwait = 0; m_csen = 4'b1011;
    #1;
    check("R10", "outputs in reset",
          32'({done, int_hit, err, pm_sel, dm_sel, cm_sel, ext_addr, rd_data}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    boot_sel_in = 1'b1; io_sel_in = 1'b0; #1;
    check("R10", "boot enable off at reset", 32'(cm_sel), 32'd0);
    boot_sel_in = 1'b0; io_sel_in = 1'b1; #1;
    check("R10", "io enable on at reset", 32'(cm_sel), 32'd1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) access(1'b0, 14'h3FE0 + 14'(i), 1'b0, 16'd0); // R10 readback

    // R1 program internal
    access(1'b1, 14'h2345, 1'b0, 0);
    access(1'b1, 14'h0100, 1'b0, 0);
    // R2 program overlays
    wr_reg(5'd0, 16'd1);
    access(1'b1, 14'h3ABC, 1'b0, 0);
    wr_reg(5'd0, 16'd2);
    access(1'b1, 14'h3ABC, 1'b1, 0);
    access(1'b1, 14'h2000, 1'b0, 0);
    access(1'b1, 14'h0010, 1'b0, 0);
    // R8 illegal program overlay
    wr_reg(5'd0, 16'd3);
    access(1'b1, 14'h2000, 1'b0, 0);
    access(1'b1, 14'h0005, 1'b0, 0);
    wr_reg(5'd0, 16'd0);
    // R3 / R6 data overlays and waits
    access(1'b0, 14'h1FFF, 1'b0, 0);
    wr_reg(5'd1, 16'd1);
    access(1'b0, 14'h1FFF, 1'b0, 0);
    wr_reg(5'd2, 16'd7);
    wr_reg(5'd1, 16'd2);
    access(1'b0, 14'h0000, 1'b1, 0);
    wr_reg(5'd2, 16'd3);
    access(1'b0, 14'h1234, 1'b0, 0);
    wr_reg(5'd1, 16'hFFF5);
    access(1'b0, 14'h0040, 1'b0, 0);   // R8
    // R4 upper data internal regardless of overlay
    access(1'b0, 14'h2000, 1'b0, 0);
    access(1'b0, 14'h3FDF, 1'b1, 0);
    // R5 unmapped offsets
    wr_reg(5'd9, 16'hFFFF);
    access(1'b0, 14'h3FE9, 1'b0, 0);
    wr_reg(5'd31, 16'h00FF);
    for (int i = 0; i < 4; i++) access(1'b0, 14'h3FE0 + 14'(i), 1'b0, 16'd0);
    // R7 mode B
    mode_b = 1'b1;
    access(1'b1, 14'h1234, 1'b0, 0);
    access(1'b1, 14'h2000, 1'b0, 0);
    wr_reg(5'd0, 16'd1);
    access(1'b1, 14'h0001, 1'b0, 0);
    wr_reg(5'd0, 16'd0);
    mode_b = 1'b0;
    // R9 enable masks
    wr_reg(5'd0, 16'd1);
    wr_reg(5'd3, 16'd0);
    access(1'b1, 14'h2222, 1'b0, 0);
    wr_reg(5'd3, 16'b0110);
    access(1'b1, 14'h2222, 1'b0, 0);

    // R11 request held through a long access
    wr_reg(5'd1, 16'd1);
    wr_reg(5'd2, 16'd3);
    req = 1'b1; req_pm = 1'b0; req_we = 1'b0; req_addr = 14'h0123;
    @(posedge clk); @(negedge clk);
    req_addr = 14'h2100;
    for (int c = 1; c <= 4; c++) begin
      #1;
      check("R11", "held req ignored: dm_sel/done", 32'({dm_sel, done, int_hit}),
            32'({1'b1, c == 4, 1'b0}));
      check("R11", "held req ignored: ext_addr", 32'(ext_addr), 32'h0123);
      @(negedge clk);
    end
    #1;
    check("R11", "idle cycle after done", 32'({done, int_hit, dm_sel}), 32'd0);
    @(negedge clk);
    req = 1'b0;
    #1;
    check("R11", "held req accepted", 32'({int_hit, done}), 32'b11);
    @(negedge clk);

    // random phase
    for (int i = 0; i < 400; i++) begin
      bit pm, we;
      logic [13:0] a;
      logic [15:0] wd;
      int r;
      pm = 1'($urandom % 2);
      we = 1'($urandom % 2);
      r = $urandom % 8;
      case (r)
        0: a = 14'h1FFF;
        1: a = 14'h2000;
        2: a = 14'h3FDF;
        3: begin a = 14'h3FE0 + 14'($urandom % 6); pm = 1'b0; end
        4: a = 14'h3FFF;
        default: a = 14'($urandom);
      endcase
      wd = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 4);
      mode_b = ($urandom % 4 == 0);
      access(pm, a, we, wd);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule